// File: doc/BRIEF.md
# Exception Vector Base Register Unit

This unit holds the 32-bit exception base register of a control coprocessor and works out where instruction fetch must go when an exception is taken. Software reaches the register through a masked write port and a read port. Part of the register can always be written. A read-only processor number sits in the low bits. The two top address bits can only be changed when a build option allows it and the written value also sets the gate bit.

When the pipeline signals exception entry, it gives the exception code, the bootstrap-vector and exception-level status flags, two configuration flags that permit cached cache-error handling, the resume address and the current cause word. One cycle later the unit issues the handler PC together with a strobe that sets the exception level. In the same edge it updates the saved exception PC and the cause word. Cache-error exceptions are sent into the uncached kernel window unless both configuration flags allow the cached base to be used.

Top module: `exc_vector_unit`

## Requirements
- R1: After reset the base register reads 0x80000000 OR the `cpuIndex` strap in bits 9:0; `epc`, `causeOut` and `handlerPc` are 0 and `handlerValid` and `setExl` are low.
- R2: A write sets base bits 29:12 to the written value. Bits 9:0 always keep the `cpuIndex` value, and a write has no effect on them.
- R3: Bit 11 is the write-gate bit. It takes the written value only when parameter `WG_EN` is 1; with `WG_EN` = 0 it reads 0 whatever is written.
- R4: Bits 31:30 take the written value only when `WG_EN` is 1 and bit 11 of the written data is 1; otherwise they keep their old value.
- R5: With `statusBev` = 1 the handler PC is `BOOT_BASE` + 0x200 + offset. The offset is 0x100 for exception code 30 (cache error) and 0x180 for every other code.
- R6: For code 30 with `statusBev` = 0, the handler PC is (0xA0000000 OR (base AND 0x1FFFF000)) + 0x100, unless `cfgSc` and `cfgCv` are both 1.
- R7: In every other case with `statusBev` = 0, the handler PC is the base with bits 11:0 cleared, plus the offset.
- R8: On exception entry `epc` takes `resumePc` only when `statusExl` is 0; otherwise `epc` is unchanged.
- R9: On exception entry `causeOut` equals `causeIn`, with bits 6:2 replaced by the 5-bit exception code.
- R10: `handlerValid` and `setExl` are both high for exactly the one cycle after an `excValid` cycle and low otherwise.
- R11: `rdData` shows the register value, and a write appears on it in the cycle after the write cycle. An exception taken in the same cycle as a write uses the old base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuIndex | input | 10 | Static processor number strap |
| wrEn | input | 1 | Base register write strobe |
| wrData | input | 32 | Base register write value |
| rdData | output | 32 | Base register read value |
| excValid | input | 1 | Exception entry strobe |
| excCode | input | 5 | Exception code |
| statusBev | input | 1 | Bootstrap-vector status flag |
| statusExl | input | 1 | Exception-level status flag |
| cfgSc | input | 1 | Config flag: segment control present |
| cfgCv | input | 1 | Config flag: cache-error vector may be cached |
| resumePc | input | 32 | Address at which to resume after the handler |
| causeIn | input | 32 | Current cause word |
| handlerPc | output | 32 | Handler fetch address |
| handlerValid | output | 1 | Handler PC valid pulse |
| setExl | output | 1 | Set exception-level strobe |
| epc | output | 32 | Saved exception PC |
| causeOut | output | 32 | Updated cause word |

## Verification
The hardest situation to reach is a cache error that is sent to the uncached window from a base whose top bits were moved away from the reset segment. To get there, bits 31:30 must first be rewritten, which is only possible through a gated write with bit 11 set. The stimulus therefore moves the base to 0x4ABCD000 with a gated write, then takes cache errors and general exceptions, so the forced 0xA0000000 segment can be told apart from a plain copy of the base. A second instance built with the gate disabled gets an all-ones write, which shows that bits 31:30 and bit 11 stay fixed.

// File: rtl/exc_vector_pkg.sv
package exc_vector_pkg;
  localparam int XLEN = 32;
  localparam int CODE_W = 5;
  localparam int CPU_W = 10;
  localparam int OFF_W = 12;
  localparam logic [CODE_W-1:0] CODE_CACHE_ERR = 5'd30;

  typedef enum logic [1:0] {
    VEC_BOOT    = 2'd0,
    VEC_UNCACHE = 2'd1,
    VEC_BASE    = 2'd2
  } vecMode_e;

  typedef struct packed {
    logic             loadBase;
    logic             takeExc;
    logic             saveEpc;
    vecMode_e         mode;
    logic [OFF_W-1:0] offset;
  } ctrlStrobes_t;
endpackage

// File: rtl/exc_vector_ctrl.sv
module exc_vector_ctrl
  import exc_vector_pkg::*;
(
  input  logic              wrEn,
  input  logic              excValid,
  input  logic [CODE_W-1:0] excCode,
  input  logic              statusBev,
  input  logic              statusExl,
  input  logic              cfgSc,
  input  logic              cfgCv,
  output ctrlStrobes_t      strobes
);
  localparam logic [OFF_W-1:0] OFF_CACHE = 12'h100;
  localparam logic [OFF_W-1:0] OFF_GENERAL = 12'h180;

  logic isCacheErr;
  logic cachedAllowed;

  always_comb begin
    isCacheErr = (excCode == CODE_CACHE_ERR);
    cachedAllowed = cfgSc && cfgCv;
    strobes.loadBase = wrEn;
    strobes.takeExc = excValid;
    strobes.saveEpc = excValid && !statusExl;
    strobes.offset = isCacheErr ? OFF_CACHE : OFF_GENERAL;
    if (statusBev)
      strobes.mode = VEC_BOOT;
    else if (isCacheErr && !cachedAllowed)
      strobes.mode = VEC_UNCACHE;
    else
      strobes.mode = VEC_BASE;
  end
endmodule

// File: rtl/exc_vector_datapath.sv
module exc_vector_datapath
  import exc_vector_pkg::*;
#(
  parameter bit WG_EN = 1'b1,
  parameter logic [XLEN-1:0] BOOT_BASE = 32'hBFC0_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [CPU_W-1:0]  cpuIndex,
  input  logic [XLEN-1:0]   wrData,
  input  logic [CODE_W-1:0] excCode,
  input  logic [XLEN-1:0]   resumePc,
  input  logic [XLEN-1:0]   causeIn,
  output logic [XLEN-1:0]   baseValue,
  output logic [XLEN-1:0]   handlerPc,
  output logic              handlerValid,
  output logic              setExl,
  output logic [XLEN-1:0]   epc,
  output logic [XLEN-1:0]   causeOut
);
  localparam int GATE_POS = 11;
  localparam int CODE_LSB = 2;
  localparam logic [XLEN-1:0] MID_MASK = 32'h3FFF_F000;
  localparam logic [XLEN-1:0] TOP_MASK = 32'hC000_0000;
  localparam logic [XLEN-1:0] GATE_MASK = XLEN'(1) << GATE_POS;
  localparam logic [XLEN-1:0] UNC_SEG = 32'hA000_0000;
  localparam logic [XLEN-1:0] UNC_KEEP = 32'h1FFF_F000;
  localparam logic [XLEN-1:0] BOOT_GAP = 32'h0000_0200;
  localparam logic [XLEN-1:0] RESET_TOP = 32'h8000_0000;
  localparam logic [XLEN-1:0] CODE_MASK = ((XLEN'(1) << CODE_W) - 1) << CODE_LSB;

  logic [XLEN-1:0] baseReg;
  logic [XLEN-1:0] wrMask;
  logic [XLEN-1:0] nextBase;
  logic [XLEN-1:0] offsetExt;
  logic [XLEN-1:0] nextPc;
  logic [XLEN-1:0] nextCause;

  always_comb begin
    wrMask = MID_MASK;
    if (WG_EN) begin
      wrMask = wrMask | GATE_MASK;
      if (wrData[GATE_POS]) wrMask = wrMask | TOP_MASK;
    end
    nextBase = (baseReg & ~wrMask) | (wrData & wrMask);
  end

  always_comb begin
    offsetExt = {{(XLEN-OFF_W){1'b0}}, strobes.offset};
    unique case (strobes.mode)
      VEC_BOOT:    nextPc = BOOT_BASE + BOOT_GAP + offsetExt;
      VEC_UNCACHE: nextPc = (UNC_SEG | (baseReg & UNC_KEEP)) + offsetExt;
      default:     nextPc = {baseReg[XLEN-1:OFF_W], {OFF_W{1'b0}}} + offsetExt;
    endcase
    nextCause = (causeIn & ~CODE_MASK) | ({{(XLEN-CODE_W){1'b0}}, excCode} << CODE_LSB);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= RESET_TOP | {{(XLEN-CPU_W){1'b0}}, cpuIndex};
      handlerPc <= '0;
      handlerValid <= 1'b0;
      setExl <= 1'b0;
      epc <= '0;
      causeOut <= '0;
    end else begin
      if (strobes.loadBase) baseReg <= nextBase;
      handlerValid <= strobes.takeExc;
      setExl <= strobes.takeExc;
      if (strobes.takeExc) begin
        handlerPc <= nextPc;
        causeOut <= nextCause;
      end
      if (strobes.saveEpc) epc <= resumePc;
    end
  end

  assign baseValue = baseReg;
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_vector_pkg::*;
#(
  parameter bit WG_EN = 1'b1,
  parameter logic [31:0] BOOT_BASE = 32'hBFC0_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [9:0]  cpuIndex,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic        excValid,
  input  logic [4:0]  excCode,
  input  logic        statusBev,
  input  logic        statusExl,
  input  logic        cfgSc,
  input  logic        cfgCv,
  input  logic [31:0] resumePc,
  input  logic [31:0] causeIn,
  output logic [31:0] handlerPc,
  output logic        handlerValid,
  output logic        setExl,
  output logic [31:0] epc,
  output logic [31:0] causeOut
);
  ctrlStrobes_t strobes;

  exc_vector_ctrl u_ctrl (
    .wrEn(wrEn), .excValid(excValid), .excCode(excCode),
    .statusBev(statusBev), .statusExl(statusExl),
    .cfgSc(cfgSc), .cfgCv(cfgCv), .strobes(strobes)
  );

  exc_vector_datapath #(.WG_EN(WG_EN), .BOOT_BASE(BOOT_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cpuIndex(cpuIndex),
    .wrData(wrData), .excCode(excCode), .resumePc(resumePc),
    .causeIn(causeIn), .baseValue(rdData), .handlerPc(handlerPc),
    .handlerValid(handlerValid), .setExl(setExl), .epc(epc),
    .causeOut(causeOut)
  );
endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic [9:0]  cpuIndex,
  input logic        wrEn,
  input logic [31:0] wrData,
  input logic [31:0] rdData,
  input logic        excValid,
  input logic [4:0]  excCode,
  input logic        statusBev,
  input logic        statusExl,
  input logic        cfgSc,
  input logic        cfgCv,
  input logic [31:0] handlerPc,
  input logic        handlerValid,
  input logic        setExl,
  input logic [31:0] epc,
  input logic [31:0] causeOut
);
  p_cpu_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdData[9:0] == cpuIndex);

  p_top_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[11]) |=> rdData[31:30] == $past(rdData[31:30]));

  p_no_write_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdData));

  p_uncached_seg_r6: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && !statusBev && excCode == 5'd30 && !(cfgSc && cfgCv))
      |=> handlerPc[31:29] == 3'b101);

  p_epc_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && statusExl) |=> $stable(epc));

  p_cause_code_r9: assert property (@(posedge clk) disable iff (!rstN)
    excValid |=> causeOut[6:2] == $past(excCode));

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    excValid |=> (handlerValid && setExl));

  p_no_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    !excValid |=> (!handlerValid && !setExl));
endmodule

bind exc_vector_unit exc_vector_unit_chk u_chk (.*);

// File: tb/exc_vector_unit_bench.sv
module exc_vector_unit_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic excValid = 1'b0;
  logic [4:0] excCode = '0;
  logic statusBev = 1'b0, statusExl = 1'b0, cfgSc = 1'b0, cfgCv = 1'b0;
  logic [31:0] resumePc = '0, causeIn = '0;
  logic [31:0] rdData, handlerPc, epc, causeOut;
  logic handlerValid, setExl;
  logic [31:0] rdData2, handlerPc2, epc2, causeOut2;
  logic handlerValid2, setExl2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  exc_vector_unit u_exc_vector_unit (
    .clk(clk), .rstN(rstN), .cpuIndex(10'h2A5), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .excValid(excValid), .excCode(excCode),
    .statusBev(statusBev), .statusExl(statusExl), .cfgSc(cfgSc), .cfgCv(cfgCv),
    .resumePc(resumePc), .causeIn(causeIn), .handlerPc(handlerPc),
    .handlerValid(handlerValid), .setExl(setExl), .epc(epc), .causeOut(causeOut)
  );

  exc_vector_unit #(.WG_EN(1'b0)) u_exc_vector_unit_nowg (
    .clk(clk), .rstN(rstN), .cpuIndex(10'h013), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData2), .excValid(excValid), .excCode(excCode),
    .statusBev(statusBev), .statusExl(statusExl), .cfgSc(cfgSc), .cfgCv(cfgCv),
    .resumePc(resumePc), .causeIn(causeIn), .handlerPc(handlerPc2),
    .handlerValid(handlerValid2), .setExl(setExl2), .epc(epc2), .causeOut(causeOut2)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic writeBase(input logic [31:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrData = val;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic takeExc(input logic bev, input logic exl, input logic sc,
                         input logic cv, input logic [4:0] code);
    @(negedge clk);
    excValid = 1'b1; statusBev = bev; statusExl = exl;
    cfgSc = sc; cfgCv = cv; excCode = code;
    @(negedge clk);
    excValid = 1'b0;
  endtask

  // {bev, sc, cv, code, expected handler PC}; base is 0x923452A5
  localparam int NVEC = 7;
  localparam logic [39:0] VECS [NVEC] = '{
    {1'b1, 1'b0, 1'b0, 5'd30, 32'hBFC0_0300},  // R5 boot, cache error
    {1'b1, 1'b0, 1'b0, 5'd4,  32'hBFC0_0380},  // R5 boot, general
    {1'b0, 1'b0, 1'b0, 5'd30, 32'hB234_5100},  // R6 forced uncached
    {1'b0, 1'b1, 1'b0, 5'd30, 32'hB234_5100},  // R6 only one flag
    {1'b0, 1'b1, 1'b1, 5'd30, 32'h9234_5100},  // R7 both flags -> base
    {1'b0, 1'b0, 1'b0, 5'd8,  32'h9234_5180},  // R7 general
    {1'b0, 1'b1, 1'b1, 5'd0,  32'h9234_5180}   // R7 general, flags set
  };

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 base", rdData, 32'h8000_02A5);
    check("R1 base nowg", rdData2, 32'h8000_0013);
    check("R1 epc", epc, 32'h0);
    check("R1 cause", causeOut, 32'h0);
    check("R1 handlerValid", {31'h0, handlerValid}, 32'h0);

    // R2 mid bits written, cpu bits kept; R4 top bits kept
    writeBase(32'h1234_5000);
    check("R2 write mid", rdData, 32'h9234_52A5);

    for (int i = 0; i < NVEC; i++) begin
      takeExc(VECS[i][39], 1'b1, VECS[i][38], VECS[i][37], VECS[i][36:32]);
      check($sformatf("R5/R6/R7 vec%0d pc", i), handlerPc, VECS[i][31:0]);
      check($sformatf("R10 vec%0d setExl", i), {30'h0, handlerValid, setExl}, 32'h3);
      @(negedge clk);
      check($sformatf("R10 vec%0d pulse end", i), {30'h0, handlerValid, setExl}, 32'h0);
    end

    // R4 gated write moves top bits; R3 gate bit stored
    writeBase(32'h4ABC_D800);
    check("R4 gated write", rdData, 32'h4ABC_DAA5);
    check("R3 no gate instance", rdData2, 32'h8ABC_D013);
    takeExc(1'b0, 1'b1, 1'b0, 1'b0, 5'd30);
    check("R6 uncached from moved base", handlerPc, 32'hAABC_D100);
    takeExc(1'b0, 1'b1, 1'b0, 1'b0, 5'd2);
    check("R7 general from moved base", handlerPc, 32'h4ABC_D180);

    // R4 ungated write keeps top; R3 gate bit cleared by write
    writeBase(32'h0000_1000);
    check("R4 top kept", rdData, 32'h4000_12A5);

    // R3 disabled gate: top and bit 11 fixed, cpu bits fixed (R2)
    writeBase(32'hFFFF_FFFF);
    check("R3 nowg all ones", rdData2, 32'hBFFF_F013);
    check("R2 cpu bits", rdData, 32'hFFFF_FAA5);

    // R11 write and exception in the same cycle: old base used
    writeBase(32'h0000_0000);
    check("R4 gate low keeps top", rdData, 32'hC000_02A5);
    @(negedge clk);
    wrEn = 1'b1; wrData = 32'h0123_4000;
    excValid = 1'b1; statusBev = 1'b0; statusExl = 1'b1; excCode = 5'd1;
    check("R11 before edge", rdData, 32'hC000_02A5);
    @(negedge clk);
    wrEn = 1'b0; excValid = 1'b0;
    check("R11 old base used", handlerPc, 32'hC000_0180);
    check("R11 write visible", rdData, 32'hC123_42A5);

    // R8 and R9
    causeIn = 32'hFFFF_FFFF; resumePc = 32'h0040_0010;
    takeExc(1'b0, 1'b0, 1'b0, 1'b0, 5'h0A);
    check("R8 epc saved", epc, 32'h0040_0010);
    check("R9 cause merge", causeOut, 32'hFFFF_FFAB);
    causeIn = 32'h0; resumePc = 32'h0050_0020;
    takeExc(1'b0, 1'b1, 1'b0, 1'b0, 5'd30);
    check("R8 epc held", epc, 32'h0040_0010);
    check("R9 cause code30", causeOut, 32'h0000_0078);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule